// File: doc/BRIEF.md
# Pointer-Addressed Configuration Bank with Key-Guarded Soft Reset

This block holds the configuration of a two-wire bus controller behind a byte-wide host interface that has only two ports. A write to the pointer port picks one of eight internal slots. Every later access to the data port reads or writes the slot the pointer names. The pointer keeps its value until the host writes it again. The implemented slots are:

- the controller's own bus address
- a timeout count
- a speed-class selector
- the clock low-phase count
- the clock high-phase count

Each slot drives a dedicated output, so the bus engine and the clock generator can use the values directly. Reads are combinational and have no side effects.

One slot, index 6, is a write-only key register. It returns every setting, and the pointer, to its power-up value only after two consecutive writes to it carry 0xA5 and then 0x5A. Any other byte written there disarms the sequence. A one-cycle pulse tells the surrounding logic that a soft reset happened. After that pulse, the speed and clock-phase settings must be programmed again.

Top module: `cfg_regbank_top`

## Requirements
- R1: A write with `bus_port`=0 loads the low PTR_W (3) bits of `bus_wdata` into the pointer. A read with `bus_port`=0 returns the pointer zero-extended to 8 bits.
- R2: A write with `bus_port`=1 stores `bus_wdata` into the slot the pointer names. A read with `bus_port`=1 returns that slot's value in the same cycle. The slot indexes are: 0 own address, 1 timeout, 2 speed class, 3 clock low count, 4 clock high count.
- R3: The own-address slot keeps the last byte written to it (for example 0xAA). Writes to the timeout slot do not change it.
- R4: The speed-class slot keeps only bits [1:0]: 0 = standard, 1 = fast, 2 = fast-plus, 3 = turbo. Bits [7:2] read back as 0, and `mode_o` shows the field.
- R5: A 0xA5 write followed by a 0x5A write, both to the key slot (index 6), resets every slot to its default and sets the pointer to 0 at the edge of the 0x5A write.
- R6: Between the two key bytes, only a write to the key slot advances or clears the key detector. A byte other than the expected next one, including a second 0xA5, returns the detector to its idle state. Pointer writes and writes to other slots do not change the detector.
- R7: `soft_rst_o` is high for exactly one cycle, the cycle that follows the edge at which the 0x5A key byte is written.
- R8: Data-port reads at indexes 5, 6 and 7 return 0x00. Writes to indexes 5 and 7 change no slot.
- R9: After `rst_n` is low, the slots hold: own address 0x00, timeout 0xFF, speed class 0 (standard), clock low count 0x9D, clock high count 0x86. The pointer holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_port | input | 1 | 0 selects the pointer port, 1 selects the data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port selected by `bus_port` |
| own_addr_o | output | 8 | Own bus address setting |
| timeout_o | output | 8 | Timeout count setting |
| mode_o | output | 2 | Speed class setting |
| scl_lo_o | output | 8 | Clock low-phase count |
| scl_hi_o | output | 8 | Clock high-phase count |
| soft_rst_o | output | 1 | One-cycle pulse after a keyed soft reset |

## Verification
The hardest state to reach from the ports is an armed key detector that meets an interruption. This happens when a pointer write comes between the two key bytes, when a wrong byte is written, or when 0xA5 is repeated. Each of these must be told apart from a real reset. The stimulus arms the detector and then applies each interruption in turn. It then writes 0x5A and confirms that only the sequence broken by a pointer rewrite fires. It does this by checking that slots programmed beforehand keep their values, or fall back to their defaults. A behavioural model runs next to the design and checks every output on every cycle, so a missed or extra pulse is caught in the exact cycle it occurs.

// File: rtl/cfg_regbank_pkg.sv
// Shared constants and types for the configuration bank.
// Assumes 8-bit bus data; slot layout fixed here, widths derived elsewhere.
package cfg_regbank_pkg;

    localparam int DATA_W = 8;
    localparam int NUM_SLOTS = 5;

    localparam int IDX_OWN  = 0;
    localparam int IDX_TMO  = 1;
    localparam int IDX_SPD  = 2;
    localparam int IDX_SLO  = 3;
    localparam int IDX_SHI  = 4;
    localparam int IDX_KEY  = 6;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hA5;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'h5A;

    typedef enum logic [1:0] {
        SPD_STANDARD = 2'd0,
        SPD_FAST     = 2'd1,
        SPD_FASTPLUS = 2'd2,
        SPD_TURBO    = 2'd3
    } speed_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;

    // Power-up value of each slot.
    function automatic logic [DATA_W-1:0] slot_default(input int idx);
        case (idx)
            IDX_OWN: return 8'h00;
            IDX_TMO: return 8'hFF;
            IDX_SPD: return {6'd0, SPD_STANDARD};
            IDX_SLO: return 8'h9D;
            IDX_SHI: return 8'h86;
            default: return '0;
        endcase
    endfunction

    // Bits of each slot that hold state.
    function automatic logic [DATA_W-1:0] slot_mask(input int idx);
        case (idx)
            IDX_SPD: return 8'h03;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/cfg_key_detect.sv
// Two-byte key detector for the soft-reset slot.
// Assumes key_wr is high only for data-port writes to the key slot.
// fire is combinational at the second-byte write; pulse_o follows one cycle later.
module cfg_key_detect
    import cfg_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_byte,
    output logic              fire,
    output logic              pulse_o
);

    key_state_e state_q;

    // Second key byte seen while armed.
    assign fire = key_wr && (state_q == KEY_ARMED) && (key_byte == KEY_SECOND);

    // Arm on the first byte; any write while armed returns to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KEY_IDLE;
        end else if (key_wr) begin
            if (state_q == KEY_IDLE && key_byte == KEY_FIRST)
                state_q <= KEY_ARMED;
            else
                state_q <= KEY_IDLE;
        end
    end

    // One-cycle notification of a completed key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_o <= 1'b0;
        else
            pulse_o <= fire;
    end

endmodule

// File: rtl/cfg_reg_file.sv
// Storage for the implemented configuration slots.
// Assumes clear has priority over a write in the same cycle.
module cfg_reg_file
    import cfg_regbank_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int PTR_W   = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           wr_en,
    input  logic [PTR_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [N_SLOTS-1:0][DATA_W-1:0] slots_o
);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        localparam logic [DATA_W-1:0] DEF  = slot_default(g);
        localparam logic [DATA_W-1:0] MASK = slot_mask(g);
        logic [DATA_W-1:0] q;

        // Load the default on reset or key, else take masked writes.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                q <= DEF;
            else if (wr_en && (int'(wr_idx) == g))
                q <= wr_data & MASK;
        end

        assign slots_o[g] = q;
    end

endmodule

// File: rtl/cfg_read_mux.sv
// Combinational read path for both host ports.
// Assumes indexes at or above N_SLOTS read as zero.
module cfg_read_mux
    import cfg_regbank_pkg::*;
#(
    parameter int N_SLOTS = NUM_SLOTS,
    parameter int PTR_W   = 3
) (
    input  logic                           port_sel,
    input  logic [PTR_W-1:0]               ptr,
    input  logic [N_SLOTS-1:0][DATA_W-1:0] slots,
    output logic [DATA_W-1:0]              rdata
);

    // Pointer port returns the pointer, data port the selected slot.
    always_comb begin
        rdata = '0;
        if (!port_sel)
            rdata[PTR_W-1:0] = ptr;
        else if (int'(ptr) < N_SLOTS)
            rdata = slots[ptr];
    end

endmodule

// File: rtl/cfg_regbank_top.sv
// Pointer/data configuration bank with a keyed soft reset.
// Assumes one host access per cycle, with synchronous active-low reset.
// Slot values drive dedicated outputs for the bus engine.
module cfg_regbank_top
    import cfg_regbank_pkg::*;
#(
    parameter int PTR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_port,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        own_addr_o,
    output logic [7:0]        timeout_o,
    output logic [1:0]        mode_o,
    output logic [7:0]        scl_lo_o,
    output logic [7:0]        scl_hi_o,
    output logic              soft_rst_o
);

    localparam logic [PTR_W-1:0] KEY_PTR = PTR_W'(IDX_KEY);

    logic [PTR_W-1:0]                ptr_q;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slots;
    logic                            key_fire;
    logic                            key_wr;
    logic                            data_wr;

    assign data_wr = bus_wr && bus_port;
    assign key_wr  = data_wr && (ptr_q == KEY_PTR);

    // Pointer register: loaded from the pointer port, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || key_fire)
            ptr_q <= '0;
        else if (bus_wr && !bus_port)
            ptr_q <= bus_wdata[PTR_W-1:0];
    end

    cfg_key_detect u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (bus_wdata),
        .fire     (key_fire),
        .pulse_o  (soft_rst_o)
    );

    cfg_reg_file #(
        .N_SLOTS (NUM_SLOTS),
        .PTR_W   (PTR_W)
    ) u_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (key_fire),
        .wr_en   (data_wr),
        .wr_idx  (ptr_q),
        .wr_data (bus_wdata),
        .slots_o (slots)
    );

    cfg_read_mux #(
        .N_SLOTS (NUM_SLOTS),
        .PTR_W   (PTR_W)
    ) u_rmux (
        .port_sel (bus_port),
        .ptr      (ptr_q),
        .slots    (slots),
        .rdata    (bus_rdata)
    );

    assign own_addr_o = slots[IDX_OWN];
    assign timeout_o  = slots[IDX_TMO];
    assign mode_o     = slots[IDX_SPD][1:0];
    assign scl_lo_o   = slots[IDX_SLO];
    assign scl_hi_o   = slots[IDX_SHI];

endmodule

// File: rtl/cfg_regbank_chk.sv
// Property checker for cfg_regbank_top, attached by bind.
// Assumes the pointer is visible as ptr_q inside the top.
module cfg_regbank_chk #(
    parameter int PTR_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             bus_port,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic [PTR_W-1:0] ptr_q,
    input logic [7:0]       own_addr_o,
    input logic [1:0]       mode_o,
    input logic [7:0]       scl_lo_o,
    input logic [7:0]       scl_hi_o,
    input logic             soft_rst_o
);

    // R3
    own_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port && ptr_q == PTR_W'(0)) |=> (own_addr_o == $past(bus_wdata)));

    // R3
    own_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_port && ptr_q == PTR_W'(1)) |=> $stable(own_addr_o));

    // R5
    soft_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> (ptr_q == '0 && mode_o == 2'd0 && scl_lo_o == 8'h9D && scl_hi_o == 8'h86));

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // R7
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst_o) |-> $past(bus_wr && bus_port && bus_wdata == 8'h5A));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_port && int'(ptr_q) >= 5) |-> (bus_rdata == 8'h00));

endmodule

bind cfg_regbank_top cfg_regbank_chk #(.PTR_W(PTR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_port   (bus_port),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ptr_q      (ptr_q),
    .own_addr_o (own_addr_o),
    .mode_o     (mode_o),
    .scl_lo_o   (scl_lo_o),
    .scl_hi_o   (scl_hi_o),
    .soft_rst_o (soft_rst_o)
);

// File: tb/cfg_regbank_top_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module cfg_regbank_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_port = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata, own_addr_o, timeout_o, scl_lo_o, scl_hi_o;
    logic [1:0] mode_o;
    logic       soft_rst_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfg_regbank_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_port(bus_port),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .own_addr_o(own_addr_o),
        .timeout_o(timeout_o), .mode_o(mode_o), .scl_lo_o(scl_lo_o),
        .scl_hi_o(scl_hi_o), .soft_rst_o(soft_rst_o)
    );

    // Reference model state.
    int m_slot[5];
    int m_ptr;
    bit m_armed;
    bit m_pulse;

    function automatic int def_of(int i);
        int d[5] = '{0, 255, 0, 157, 134};
        return d[i];
    endfunction

    task automatic model_defaults();
        foreach (m_slot[i]) m_slot[i] = def_of(i);
        m_ptr = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_defaults();
            m_armed = 0;
            m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (bus_wr && !bus_port) begin
                m_ptr = bus_wdata % 8;
            end else if (bus_wr) begin
                if (m_ptr == 2) m_slot[2] = bus_wdata % 4;
                else if (m_ptr < 5) m_slot[m_ptr] = bus_wdata;
                else if (m_ptr == 6) begin
                    if (m_armed && bus_wdata == 8'h5A) begin
                        model_defaults();
                        m_pulse = 1;
                        m_armed = 0;
                    end else begin
                        m_armed = !m_armed && bus_wdata == 8'hA5;
                    end
                end
            end
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", own_addr_o, m_slot[0]);
            check("R2", timeout_o, m_slot[1]);
            check("R4", mode_o, m_slot[2]);
            check("R2", scl_lo_o, m_slot[3]);
            check("R2", scl_hi_o, m_slot[4]);
            check("R7", soft_rst_o, m_pulse);
            if (!bus_port) check("R1", bus_rdata, m_ptr);
            else check("R2", bus_rdata, (m_ptr < 5) ? m_slot[m_ptr] : 0);
        end
    end

    task automatic put(bit port, logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_port = port; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic get(bit port, output logic [7:0] v);
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_port = port;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state
        @(negedge clk);
        check("R9", own_addr_o, 8'h00);
        check("R9", timeout_o, 8'hFF);
        check("R9", mode_o, 0);
        check("R9", scl_lo_o, 8'h9D);
        check("R9", scl_hi_o, 8'h86);
        get(0, v); check("R9", v, 0);
        // R1 pointer load and readback, upper bits dropped
        put(0, 8'h02); get(0, v); check("R1", v, 2);
        put(0, 8'hFB); get(0, v); check("R1", v, 3);
        // R3 own address survives timeout write
        put(0, 8'h00); put(1, 8'hAA);
        put(0, 8'h01); put(1, 8'h00);
        put(0, 8'h00); get(1, v); check("R3", v, 8'hAA);
        // R4 speed field masking
        put(0, 8'h02); put(1, 8'hFF); get(1, v); check("R4", v, 3);
        check("R4", mode_o, 3);
        put(1, 8'h01); get(1, v); check("R4", v, 1);
        // R2 clock counts
        put(0, 8'h03); put(1, 8'h2C); get(1, v); check("R2", v, 8'h2C);
        put(0, 8'h04); put(1, 8'h14); get(1, v); check("R2", v, 8'h14);
        // R8 empty indexes
        put(0, 8'h05); put(1, 8'h77); get(1, v); check("R8", v, 0);
        put(0, 8'h07); put(1, 8'h99); get(1, v); check("R8", v, 0);
        put(0, 8'h06); get(1, v); check("R8", v, 0);
        // R6 wrong middle byte
        put(1, 8'hA5); put(1, 8'h33); put(1, 8'h5A);
        @(negedge clk); check("R6", scl_lo_o, 8'h2C);
        // R6 repeated first byte
        put(1, 8'hA5); put(1, 8'hA5); put(1, 8'h5A);
        @(negedge clk); check("R6", mode_o, 1);
        // R6 lone second byte
        put(1, 8'h5A);
        @(negedge clk); check("R6", own_addr_o, 8'hAA);
        // R6 pointer rewrite between bytes keeps the detector armed; R5, R7
        put(1, 8'hA5); put(0, 8'h06); put(1, 8'h5A);
        check("R7", soft_rst_o, 1);
        @(negedge clk); check("R7", soft_rst_o, 1);
        @(negedge clk); check("R7", soft_rst_o, 0);
        check("R5", own_addr_o, 8'h00);
        check("R5", mode_o, 0);
        check("R5", scl_lo_o, 8'h9D);
        check("R5", scl_hi_o, 8'h86);
        get(0, v); check("R5", v, 0);
        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule